// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down-counter is loaded and read through an 8-bit port, one byte per access, low byte first. A control word written to the same port picks the counting mode or asks for a snapshot of the count. The counter decrements on a fixed-rate tick strobe, nominally 1,193,180 Hz. It drives a single output whose waveform depends on the mode: a level that rises when the count runs out, a periodic one-tick low pulse, or a square wave.

The host issues single-cycle strobes. `wr_en` with `wr_ctl` high writes a control word, and `wr_en` with `wr_ctl` low writes a count byte. `rd_en` consumes the byte currently shown on `rd_data`. Only binary counting and the two-byte access order are supported. Any other request is rejected and raises `cfg_err`. A rejected request changes nothing else. The asynchronous reset input is synchronised inside the block before it is used.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, both byte pointers select the low byte, no snapshot is held, the mode is terminal-count, `out_pin` is low and `cfg_err` is low.
- R2: Count writes alternate low byte then high byte. A low-byte write replaces bits [7:0] of the count, halts counting and drives `out_pin` low.
- R3: A high-byte write replaces bits [15:8], copies the full count into the period register and starts counting only if the 16-bit value is nonzero. At that write `out_pin` goes low in terminal-count mode and high in the other two modes.
- R4: `rd_data` shows the low byte and then, after one `rd_en`, the high byte. A second `rd_en` returns it to the low byte.
- R5: A latch control word copies the current count into a snapshot and points reads at its low byte, but only if no snapshot is already held. While a snapshot is held, reads come from it. The `rd_en` that consumes its high byte releases it.
- R6: In terminal-count mode (mode code 0) each tick decrements the count. The tick that takes it from 1 to 0 raises `out_pin` and stops counting. `out_pin` then stays high until a write.
- R7: In rate mode (mode code 2) a tick at count 1 reloads the period, and otherwise decrements. `out_pin` is low exactly while the count equals 1.
- R8: In square mode (mode code 3) each tick subtracts 2. A tick at a count of 2 or less reloads the period and toggles `out_pin`.
- R9: Control word fields are: [7:6] channel select, [5:4] access (0 latch, 3 low-then-high, 1 and 2 unsupported), [3:1] mode, [0] BCD. A select of 3 sets `cfg_err`. A word for this channel with access 1 or 2, a mode other than 0, 2 or 3, or BCD set also sets `cfg_err`. An accepted word clears `cfg_err`. A word for another channel has no effect.
- R10: An accepted mode word stores the mode, halts counting, returns both byte pointers to the low byte, and sets `out_pin` low for mode 0 or high for modes 2 and 3.
- R11: A count-byte write in the same cycle as a tick wins, and the tick is lost. A latch command in the same cycle as a tick captures the count from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-rate strobe, one cycle per count step |
| wr_en | input | 1 | Write strobe |
| wr_ctl | input | 1 | With `wr_en`: 1 = control word, 0 = count byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Consumes the byte shown on `rd_data` |
| rd_data | output | 8 | Byte at the read pointer, from the snapshot or the live count |
| out_pin | output | 1 | Counter output |
| cfg_err | output | 1 | Last control word was rejected |

## Verification
Two collisions are provoked on purpose. A latch command and a tick land in one cycle, and the snapshot must then equal the value from before the decrement while the live count moves on. A count-byte write and a tick also land in one cycle, and the written value must be seen unchanged with counting halted or re-armed. Both are driven as directed steps with literal expected bytes. They then recur many times in a randomised phase, where a behavioural model judges every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    PM_TC     = 3'd0,
    PM_RATE   = 3'd2,
    PM_SQUARE = 3'd3
  } pit_mode_e;

  localparam logic [1:0] ACC_LATCH  = 2'd0;
  localparam logic [1:0] ACC_WORD   = 2'd3;
  localparam logic [1:0] SEL_RDBACK = 2'd3;

endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode
  import pit_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CHAN_ID = 0
) (
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              latch_cmd,
  output logic              mode_ld,
  output pit_mode_e         mode_val,
  output logic              err_set,
  output logic              err_clr
);

  localparam logic [1:0] MY_SEL = CHAN_ID[1:0];

  logic [1:0] sel_f;
  logic [1:0] acc_f;
  logic [2:0] mode_f;
  logic       bcd_f;
  logic       is_ctl;
  logic       mode_ok;

  always_comb begin
    sel_f  = wr_data[7:6];
    acc_f  = wr_data[5:4];
    mode_f = wr_data[3:1];
    bcd_f  = wr_data[0];
    is_ctl = wr_en & wr_ctl;

    case (mode_f)
      3'd0:    begin mode_ok = 1'b1; mode_val = PM_TC;     end
      3'd2:    begin mode_ok = 1'b1; mode_val = PM_RATE;   end
      3'd3:    begin mode_ok = 1'b1; mode_val = PM_SQUARE; end
      default: begin mode_ok = 1'b0; mode_val = PM_TC;     end
    endcase

    latch_cmd = 1'b0;
    mode_ld   = 1'b0;
    err_set   = 1'b0;
    err_clr   = 1'b0;
    if (is_ctl) begin
      if (sel_f == SEL_RDBACK) begin
        err_set = 1'b1;
      end else if (sel_f == MY_SEL) begin
        if (acc_f == ACC_LATCH) begin
          latch_cmd = 1'b1;
          err_clr   = 1'b1;
        end else if (acc_f == ACC_WORD && !bcd_f && mode_ok) begin
          mode_ld = 1'b1;
          err_clr = 1'b1;
        end else begin
          err_set = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pit_byte_port.sv
module pit_byte_port #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              data_we,
  input  logic              latch_cmd,
  input  logic              mode_ld,
  input  logic              rd_en,
  output logic              lo_we,
  output logic              hi_we,
  output logic [BYTE_W-1:0] rd_data,
  output logic              latched_o,
  output logic [CNT_W-1:0]  latch_val_o
);

  logic             wr_hi_q, wr_hi_d;
  logic             rd_hi_q, rd_hi_d;
  logic             lat_q, lat_d;
  logic [CNT_W-1:0] lval_q;
  logic             take;
  logic [CNT_W-1:0] src;

  always_comb begin
    take  = latch_cmd & ~lat_q;
    lo_we = data_we & ~wr_hi_q;
    hi_we = data_we &  wr_hi_q;

    wr_hi_d = wr_hi_q;
    if (mode_ld)      wr_hi_d = 1'b0;
    else if (data_we) wr_hi_d = ~wr_hi_q;

    rd_hi_d = rd_hi_q;
    if (rd_en)           rd_hi_d = ~rd_hi_q;
    if (take || mode_ld) rd_hi_d = 1'b0;

    lat_d = lat_q;
    if (rd_en && rd_hi_q) lat_d = 1'b0;
    if (take)             lat_d = 1'b1;

    src     = lat_q ? lval_q : cnt_i;
    rd_data = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      lat_q   <= 1'b0;
      lval_q  <= '0;
    end else begin
      wr_hi_q <= wr_hi_d;
      rd_hi_q <= rd_hi_d;
      lat_q   <= lat_d;
      if (take) lval_q <= cnt_i;
    end
  end

  assign latched_o   = lat_q;
  assign latch_val_o = lval_q;

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_ld,
  input  pit_mode_e         mode_val,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              running_o,
  output logic              out_o,
  output pit_mode_e         mode_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, full;
  logic             run_q, run_d, out_q, out_d, en;
  pit_mode_e        mode_q, mode_d;

  always_comb begin
    full   = {wdata, cnt_q[BYTE_W-1:0]};
    cnt_d  = cnt_q;
    per_d  = per_q;
    run_d  = run_q;
    out_d  = out_q;
    mode_d = mode_q;
    en     = mode_ld | lo_we | hi_we | (tick & run_q);

    if (mode_ld) begin
      mode_d = mode_val;
      run_d  = 1'b0;
      out_d  = (mode_val != PM_TC);
    end else if (lo_we) begin
      cnt_d = {cnt_q[CNT_W-1:BYTE_W], wdata};
      run_d = 1'b0;
      out_d = 1'b0;
    end else if (hi_we) begin
      cnt_d = full;
      per_d = full;
      run_d = |full;
      out_d = (mode_q != PM_TC);
    end else if (tick && run_q) begin
      case (mode_q)
        PM_TC: begin
          cnt_d = cnt_q - ONE;
          if (cnt_q == ONE) begin
            out_d = 1'b1;
            run_d = 1'b0;
          end
        end
        PM_RATE: begin
          cnt_d = (cnt_q == ONE) ? per_q : cnt_q - ONE;
          out_d = (cnt_d != ONE);
        end
        PM_SQUARE: begin
          if (cnt_q <= TWO) begin
            cnt_d = per_q;
            out_d = ~out_q;
          end else begin
            cnt_d = cnt_q - TWO;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
      out_q  <= 1'b0;
      mode_q <= PM_TC;
    end else if (en) begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      run_q  <= run_d;
      out_q  <= out_d;
      mode_q <= mode_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign period_o  = per_q;
  assign running_o = run_q;
  assign out_o     = out_q;
  assign mode_o    = mode_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CHAN_ID = 0,
  localparam int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              out_pin,
  output logic              cfg_err
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             latch_cmd, mode_ld, err_set, err_clr;
  pit_mode_e        mode_val, mode_q;
  logic             lo_we, hi_we, latched, running;
  logic [CNT_W-1:0] cnt_q, period_q, latch_val;
  logic             err_q, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pit_ctl_decode #(.BYTE_W(BYTE_W), .CHAN_ID(CHAN_ID)) u_dec (
    .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .latch_cmd(latch_cmd), .mode_ld(mode_ld), .mode_val(mode_val),
    .err_set(err_set), .err_clr(err_clr)
  );

  pit_byte_port #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_sync_n), .cnt_i(cnt_q),
    .data_we(wr_en & ~wr_ctl), .latch_cmd(latch_cmd), .mode_ld(mode_ld),
    .rd_en(rd_en), .lo_we(lo_we), .hi_we(hi_we), .rd_data(rd_data),
    .latched_o(latched), .latch_val_o(latch_val)
  );

  pit_down_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .lo_we(lo_we),
    .hi_we(hi_we), .wdata(wr_data), .mode_ld(mode_ld), .mode_val(mode_val),
    .cnt_o(cnt_q), .period_o(period_q), .running_o(running),
    .out_o(out_pin), .mode_o(mode_q)
  );

  always_comb begin
    err_d = err_q;
    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              wr_ctl,
  input logic [BYTE_W-1:0] wr_data,
  input logic              lo_we,
  input logic              hi_we,
  input logic              running,
  input logic              out_pin,
  input logic              cfg_err,
  input logic              latched,
  input logic [CNT_W-1:0]  latch_val,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period_q,
  input pit_mode_e         mode_q
);

  a_r2_low_write_halts: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (!running && !out_pin));

  a_r3_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && wr_data == '0 && cnt_q[BYTE_W-1:0] == '0) |=> !running);

  a_r5_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> $stable(latch_val));

  a_r6_tc_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_TC && out_pin && !wr_en) |=> out_pin);

  a_r7_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_RATE && running && tick && !wr_en && cnt_q == CNT_W'(1))
      |=> (cnt_q == period_q));

  a_r8_square_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SQUARE && running && tick && !wr_en && cnt_q > CNT_W'(2))
      |=> (cnt_q == $past(cnt_q) - CNT_W'(2)));

  a_r9_rdback_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ctl && wr_data[7:6] == 2'b11) |=> cfg_err);

endmodule

bind pit_channel pit_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .wr_en(wr_en),
  .wr_ctl(wr_ctl), .wr_data(wr_data), .lo_we(lo_we), .hi_we(hi_we),
  .running(running), .out_pin(out_pin), .cfg_err(cfg_err),
  .latched(latched), .latch_val(latch_val), .cnt_q(cnt_q),
  .period_q(period_q), .mode_q(mode_q)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_ctl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       out_pin;
  logic       cfg_err;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int m_cnt, m_per, m_mode, m_rptr, m_latv;
  bit m_run, m_out, m_whi, m_lat, m_err;

  always #5 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .out_pin(out_pin), .cfg_err(cfg_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_mode = 0; m_rptr = 0; m_latv = 0;
      m_run = 0; m_out = 0; m_whi = 0; m_lat = 0; m_err = 0;
    end else begin
      int  oc;
      bit  mode_hit;
      bit  data_hit;
      oc = m_cnt;
      mode_hit = 0;
      data_hit = wr_en && !wr_ctl;
      if (rd_en) begin
        if (m_rptr == 0) m_rptr = 1;
        else begin m_rptr = 0; m_lat = 0; end
      end
      if (wr_en && wr_ctl) begin
        int s, a, md, b;
        s = wr_data[7:6]; a = wr_data[5:4]; md = wr_data[3:1]; b = wr_data[0];
        if (s == 3) m_err = 1;
        else if (s == 0) begin
          if (a == 0) begin
            if (!m_lat) begin m_lat = 1; m_latv = oc; m_rptr = 0; end
            m_err = 0;
          end else if (a == 3 && b == 0 && (md == 0 || md == 2 || md == 3)) begin
            m_mode = md; mode_hit = 1; m_err = 0;
          end else m_err = 1;
        end
      end
      if (mode_hit) begin
        m_run = 0; m_out = (m_mode != 0); m_whi = 0; m_rptr = 0;
      end else if (data_hit) begin
        if (!m_whi) begin
          m_cnt = (m_cnt & 'hFF00) | wr_data; m_run = 0; m_out = 0; m_whi = 1;
        end else begin
          m_cnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
          m_per = m_cnt; m_run = (m_cnt != 0); m_out = (m_mode != 0); m_whi = 0;
        end
      end else if (tick && m_run) begin
        if (m_mode == 0) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_out = 1; m_run = 0; end
        end else if (m_mode == 2) begin
          if (m_cnt == 1) m_cnt = m_per; else m_cnt = m_cnt - 1;
          m_out = (m_cnt != 1);
        end else begin
          if (m_cnt <= 2) begin m_cnt = m_per; m_out = !m_out; end
          else m_cnt = m_cnt - 2;
        end
      end
    end
  end

  function automatic int exp_rd();
    int src;
    src = m_lat ? m_latv : m_cnt;
    return m_rptr ? ((src >> 8) & 'hFF) : (src & 'hFF);
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_cmp++;
      if (int'(rd_data) != exp_rd() || out_pin != m_out || cfg_err != m_err) begin
        n_bad++;
        $display("FAIL %s model: rd=%02h out=%0b err=%0b expected rd=%02h out=%0b err=%0b",
                 phase, rd_data, out_pin, cfg_err, exp_rd(), m_out, m_err);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input bit c, input logic [7:0] d,
                      input bit re, input bit tk);
    wr_en = we; wr_ctl = c; wr_data = d; rd_en = re; tick = tk;
    @(negedge clk);
    wr_en = 0; wr_ctl = 0; wr_data = 8'h00; rd_en = 0; tick = 0;
  endtask

  task automatic ctl(input logic [7:0] d); step(1, 1, d, 0, 0); endtask
  task automatic wd(input logic [7:0] d);  step(1, 0, d, 0, 0); endtask
  task automatic rd1();                    step(0, 0, 8'h00, 1, 0); endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    chk("R1 count", rd_data, 8'h00);
    chk("R1 out", out_pin, 0);
    chk("R1 err", cfg_err, 0);

    phase = "R9";
    ctl(8'hC0); chk("R9 readback sel", cfg_err, 1);
    ctl(8'h76); chk("R9 other channel", cfg_err, 1);
    ctl(8'h30); chk("R9 accepted clears", cfg_err, 0);
    ctl(8'h31); chk("R9 bcd", cfg_err, 1);
    ctl(8'h30); ctl(8'h38); chk("R9 bad mode", cfg_err, 1);
    ctl(8'h30); ctl(8'h10); chk("R9 bad access", cfg_err, 1);
    ctl(8'h30); chk("R9 clear again", cfg_err, 0);

    phase = "R6";
    wd(8'h05); chk("R2 low byte", rd_data, 8'h05);
    wd(8'h00); tk(4);
    chk("R6 count at 1", rd_data, 8'h01);
    chk("R6 out low before expiry", out_pin, 0);
    rd1(); chk("R4 high byte", rd_data, 8'h00);
    rd1(); chk("R4 back to low", rd_data, 8'h01);
    tk(1); chk("R6 out high at expiry", out_pin, 1);
    tk(3); chk("R6 stops at zero", rd_data, 8'h00);
    chk("R6 out stays", out_pin, 1);

    phase = "R2";
    wd(8'h34); wd(8'h12); tk(2);
    chk("R3 armed and counting", rd_data, 8'h32);
    wd(8'h80); tk(3);
    chk("R2 low write halts", rd_data, 8'h80);
    chk("R2 low write out low", out_pin, 0);
    rd1(); chk("R4 high byte kept", rd_data, 8'h12);
    rd1();
    phase = "R3";
    ctl(8'h30); wd(8'h00); wd(8'h00); tk(3);
    chk("R3 zero not armed", rd_data, 8'h00);

    phase = "R7";
    ctl(8'h34); chk("R10 rate idle high", out_pin, 1);
    wd(8'h03); wd(8'h00); tk(2);
    chk("R7 out low at one", out_pin, 0);
    tk(1); chk("R7 reload", rd_data, 8'h03);
    chk("R7 out high after reload", out_pin, 1);

    phase = "R8";
    ctl(8'h36); wd(8'h06); wd(8'h00); tk(2);
    chk("R8 step by two", rd_data, 8'h02);
    chk("R8 first half high", out_pin, 1);
    tk(1); chk("R8 reload", rd_data, 8'h06);
    chk("R8 toggle low", out_pin, 0);
    tk(3); chk("R8 toggle high", out_pin, 1);

    phase = "R5";
    ctl(8'h34); wd(8'h00); wd(8'h01); tk(1);
    ctl(8'h00); tk(3); ctl(8'h00); tk(1);
    chk("R5 snapshot low", rd_data, 8'hFF);
    rd1(); chk("R5 snapshot high", rd_data, 8'h00);
    rd1(); chk("R5 released to live", rd_data, 8'hFB);

    phase = "R11";
    step(1, 1, 8'h00, 0, 1);
    chk("R11 latch pre-tick", rd_data, 8'hFB);
    rd1(); rd1(); chk("R11 live moved", rd_data, 8'hFA);
    step(1, 0, 8'h50, 0, 1); chk("R11 low write beats tick", rd_data, 8'h50);
    step(1, 0, 8'h00, 0, 1); chk("R11 high write beats tick", rd_data, 8'h50);
    tk(1); chk("R11 counts after", rd_data, 8'h4F);

    phase = "R10";
    wd(8'h11); ctl(8'h30); wd(8'h22); wd(8'h00);
    chk("R10 pointer reset", rd_data, 8'h22);
    chk("R10 tc out low", out_pin, 0);

    phase = "R11 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit we, c, re, t;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      t = ($urandom_range(0, 1) == 1);
      we = 0; c = 0; re = 0; d = 8'h00;
      if (r < 8) begin
        we = 1; c = 1;
        case ($urandom_range(0, 9))
          0, 1:    d = 8'h00;
          2:       d = 8'h30;
          3:       d = 8'h34;
          4:       d = 8'h36;
          5:       d = 8'hC0;
          6:       d = 8'h76;
          7:       d = 8'h31;
          8:       d = 8'h38;
          default: d = 8'h10;
        endcase
      end else if (r < 20) begin
        we = 1; d = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 31));
      end else if (r < 35) begin
        re = 1;
      end
      step(we, c, d, re, t);
    end

    finish_run();
  end

endmodule